// File: doc/BRIEF.md
# SDRAM low-power entry controller

This block sits beside the access engine of an SDRAM controller and decides when the memory may sleep. It watches the engine's idle flag together with pending access and refresh requests. Once the memory has been idle for a selectable stretch, it sends one entry command to the command engine and drives the clock-enable pin low. In self-refresh and deep power-down it also stops the memory clock. A later access, or a refresh request in the modes that keep data, brings the memory back. The block sends an exit command and holds new accesses back until the programmed recovery time has passed.

The access request and grant pair is a valid/ready handshake. `acc_req` is valid and `acc_gnt` is ready. A transfer takes place on a rising clock edge where both are high. Once raised, the request must stay high until that edge. The grant is a registered function of the controller state and never depends combinationally on the request, so the requester may wait on it without forming a loop. Commands to the command engine are one-cycle pulses with no back-pressure. The partial-array and drive-strength settings are not decoded. They are only held in registers for the mode-register logic downstream.

Top module: `sdram_lp_ctrl`

## Requirements
- R1: After reset, `sd_cke`, `sd_clk_on` and `acc_gnt` are high and `lp_cmd_valid` is low.
- R2: The mode field `cfg_lp_mode` is coded as 0 = disabled, 1 = self-refresh, 2 = power-down, 3 = deep power-down. An entry command is a one-cycle `lp_cmd_valid` pulse whose `lp_cmd_code` equals the mode (1, 2 or 3). The exit command uses code 4.
- R3: A qualifying idle cycle is one where `eng_idle` is high, `acc_req` and `ref_req` are low, and the mode is enabled. With `cfg_idle_sel` = N, where 0 gives 0, 1 gives 64 and 2 gives 128, the entry command is issued at the edge that ends the (N+1)-th consecutive qualifying idle cycle.
- R4: `cfg_idle_sel` = 3 behaves exactly like 0: entry happens on the first qualifying idle edge.
- R5: Any non-qualifying cycle restarts the idle count from zero.
- R6: In power-down, `sd_cke` is low and `sd_clk_on` stays high. An access or refresh request exits it with code 4. In the cycle that follows, `sd_cke` and `acc_gnt` are high. The memory re-enters power-down after the access once the idle rule is met again.
- R7: In self-refresh, `sd_cke` and `sd_clk_on` are both low. An access or refresh request exits it with code 4 and raises `sd_cke` and `sd_clk_on`. `acc_gnt` then stays low for `cfg_exit_dly` cycles before it rises.
- R8: Deep power-down is entered only when `cfg_lpsdram` = 1. With 0, mode 3 counts as disabled. In deep power-down both `sd_cke` and `sd_clk_on` are low and `ref_req` is ignored. An access exits it with the same recovery wait as self-refresh.
- R9: While the mode is disabled, no entry command is ever issued and `sd_cke` stays high.
- R10: `acc_gnt` is high only while the memory is awake and any recovery wait has ended. It is low in every low-power state.
- R11: `ext_pasr` and `ext_drive` present the values of `cfg_pasr` and `cfg_drive` from one cycle earlier and have no effect on the low-power sequence.
- R12: With `cfg_exit_dly` = 0, a self-refresh exit raises `acc_gnt` in the same cycle as the exit command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lp_mode | input | 2 | Low-power mode: 0 off, 1 self-refresh, 2 power-down, 3 deep power-down |
| cfg_idle_sel | input | 2 | Idle delay before entry: 0 none, 1 short, 2 long, 3 none |
| cfg_lpsdram | input | 1 | 1 when the attached memory is low-power SDRAM |
| cfg_exit_dly | input | DLY_W | Recovery cycles after a self-refresh or deep power-down exit |
| cfg_pasr | input | PASR_W | Partial-array refresh setting, held only |
| cfg_drive | input | DS_W | Drive-strength setting, held only |
| eng_idle | input | 1 | Access engine has no transfer in flight |
| acc_req | input | 1 | Access request (valid) |
| acc_gnt | output | 1 | Access may proceed (ready) |
| ref_req | input | 1 | Refresh request pending |
| sd_cke | output | 1 | Memory clock enable |
| sd_clk_on | output | 1 | Memory clock gate enable |
| lp_cmd_valid | output | 1 | One-cycle command pulse to the command engine |
| lp_cmd_code | output | 3 | Command: 1 self-refresh, 2 power-down, 3 deep power-down, 4 exit |
| ext_pasr | output | PASR_W | Held partial-array refresh setting |
| ext_drive | output | DS_W | Held drive-strength setting |

## Verification
The bench builds the block with its default parameters: short and long idle delays of 64 and 128 cycles, and a 4-bit recovery field. The exact timeout thresholds can then be checked to the cycle. The bench runs both idle delays, the immediate setting and its alias, a restart of the timer in the middle of a count, and recovery waits of 0, 3 and 5 cycles. Deep power-down is tried with each memory type, and a refresh request is raised while the memory is in deep power-down.

// File: rtl/sdlp_pkg.sv
package sdlp_pkg;

  typedef enum logic [2:0] {
    LPS_RUN   = 3'd0,
    LPS_SELF  = 3'd1,
    LPS_PDOWN = 3'd2,
    LPS_DEEP  = 3'd3,
    LPS_WAKE  = 3'd4
  } lp_state_e;

  typedef enum logic [2:0] {
    LPC_NONE  = 3'd0,
    LPC_SELF  = 3'd1,
    LPC_PDOWN = 3'd2,
    LPC_DEEP  = 3'd3,
    LPC_EXIT  = 3'd4
  } lp_cmd_e;

  localparam logic [1:0] MODE_OFF  = 2'd0;
  localparam logic [1:0] MODE_DEEP = 2'd3;

endpackage

// File: rtl/sdlp_idle_timer.sv
module sdlp_idle_timer #(
  parameter int SHORT_IDLE = 64,
  parameter int LONG_IDLE  = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       at_limit
);
  localparam int CW = $clog2(LONG_IDLE + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  always_comb begin
    case (sel)
      2'd1:    limit = CW'(SHORT_IDLE);
      2'd2:    limit = CW'(LONG_IDLE);
      default: limit = '0;
    endcase
  end

  assign at_limit = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (!tick)     cnt <= '0;
    else if (at_limit)  cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // R3
  idle_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !at_limit |=> cnt == $past(cnt) + 1'b1);

  // R5
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> cnt == '0);

  // R3
  idle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LONG_IDLE));

endmodule

// File: rtl/sdlp_wake_delay.sv
module sdlp_wake_delay #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DLY_W-1:0] dly,
  output logic             last
);
  logic [DLY_W-1:0] rem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rem <= '0;
    else if (load)              rem <= dly - 1'b1;
    else if (run && rem != '0)  rem <= rem - 1'b1;
  end

  assign last = (rem == '0);

  // R7
  wake_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !load && rem != '0 |=> rem == $past(rem) - 1'b1);

endmodule

// File: rtl/sdlp_ext_hold.sv
module sdlp_ext_hold #(
  parameter int PASR_W = 3,
  parameter int DS_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PASR_W-1:0] pasr_in,
  input  logic [DS_W-1:0]   drive_in,
  output logic [PASR_W-1:0] pasr_q,
  output logic [DS_W-1:0]   drive_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pasr_q  <= '0;
      drive_q <= '0;
    end else begin
      pasr_q  <= pasr_in;
      drive_q <= drive_in;
    end
  end

  // R11
  ext_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pasr_q == $past(pasr_in) && drive_q == $past(drive_in));

endmodule

// File: rtl/sdlp_fsm.sv
module sdlp_fsm
  import sdlp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       lpsdram,
  input  logic       eng_idle,
  input  logic       acc_req,
  input  logic       ref_req,
  input  logic       dly_zero,
  input  logic       at_limit,
  input  logic       wake_last,
  output logic       tick,
  output logic       dly_load,
  output logic       wake_run,
  output logic       cke,
  output logic       clk_on,
  output logic       gnt,
  output logic       cmd_valid,
  output logic [2:0] cmd_code
);
  lp_state_e st_q, st_d;
  lp_cmd_e   cmd_q, cmd_d;
  logic      cmd_v_q, cmd_v_d;
  logic      mode_ok, wake_any;

  assign mode_ok  = (mode != MODE_OFF) && ((mode != MODE_DEEP) || lpsdram);
  assign tick     = (st_q == LPS_RUN) && eng_idle && !acc_req && !ref_req && mode_ok;
  assign wake_any = acc_req || ref_req;
  assign wake_run = (st_q == LPS_WAKE);

  always_comb begin
    st_d     = st_q;
    cmd_v_d  = 1'b0;
    cmd_d    = LPC_NONE;
    dly_load = 1'b0;
    unique case (st_q)
      LPS_RUN: begin
        if (tick && at_limit) begin
          st_d    = lp_state_e'({1'b0, mode});
          cmd_v_d = 1'b1;
          cmd_d   = lp_cmd_e'({1'b0, mode});
        end
      end
      LPS_SELF, LPS_DEEP: begin
        if (acc_req || (ref_req && st_q == LPS_SELF)) begin
          cmd_v_d = 1'b1;
          cmd_d   = LPC_EXIT;
          if (dly_zero) st_d = LPS_RUN;
          else begin
            st_d     = LPS_WAKE;
            dly_load = 1'b1;
          end
        end
      end
      LPS_PDOWN: begin
        if (wake_any) begin
          cmd_v_d = 1'b1;
          cmd_d   = LPC_EXIT;
          st_d    = LPS_RUN;
        end
      end
      LPS_WAKE: begin
        if (wake_last) st_d = LPS_RUN;
      end
      default: st_d = LPS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= LPS_RUN;
      cmd_v_q <= 1'b0;
      cmd_q   <= LPC_NONE;
    end else begin
      st_q    <= st_d;
      cmd_v_q <= cmd_v_d;
      cmd_q   <= cmd_d;
    end
  end

  assign cke       = (st_q == LPS_RUN) || (st_q == LPS_WAKE);
  assign clk_on    = (st_q != LPS_SELF) && (st_q != LPS_DEEP);
  assign gnt       = (st_q == LPS_RUN);
  assign cmd_valid = cmd_v_q;
  assign cmd_code  = cmd_q;

  // R9
  off_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v_q && cmd_q != LPC_EXIT |-> $past(mode) != MODE_OFF);

  // R8
  deep_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v_q && cmd_q == LPC_DEEP |-> $past(lpsdram));

  // R6
  exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_v_q && cmd_q == LPC_EXIT |-> $past(acc_req || ref_req));

  // R8
  deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == LPS_DEEP && !acc_req |=> st_q == LPS_DEEP);

  // R7
  gate_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_on |-> !cke && !gnt);

endmodule

// File: rtl/sdram_lp_ctrl.sv
module sdram_lp_ctrl
  import sdlp_pkg::*;
#(
  parameter int SHORT_IDLE = 64,
  parameter int LONG_IDLE  = 128,
  parameter int DLY_W      = 4,
  parameter int PASR_W     = 3,
  parameter int DS_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_lp_mode,
  input  logic [1:0]        cfg_idle_sel,
  input  logic              cfg_lpsdram,
  input  logic [DLY_W-1:0]  cfg_exit_dly,
  input  logic [PASR_W-1:0] cfg_pasr,
  input  logic [DS_W-1:0]   cfg_drive,
  input  logic              eng_idle,
  input  logic              acc_req,
  output logic              acc_gnt,
  input  logic              ref_req,
  output logic              sd_cke,
  output logic              sd_clk_on,
  output logic              lp_cmd_valid,
  output logic [2:0]        lp_cmd_code,
  output logic [PASR_W-1:0] ext_pasr,
  output logic [DS_W-1:0]   ext_drive
);
  logic tick, at_limit, dly_load, wake_run, wake_last;

  sdlp_idle_timer #(.SHORT_IDLE(SHORT_IDLE), .LONG_IDLE(LONG_IDLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sel(cfg_idle_sel), .at_limit(at_limit)
  );

  sdlp_wake_delay #(.DLY_W(DLY_W)) u_wake (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .run(wake_run),
    .dly(cfg_exit_dly), .last(wake_last)
  );

  sdlp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mode(cfg_lp_mode), .lpsdram(cfg_lpsdram),
    .eng_idle(eng_idle), .acc_req(acc_req), .ref_req(ref_req),
    .dly_zero(cfg_exit_dly == '0), .at_limit(at_limit), .wake_last(wake_last),
    .tick(tick), .dly_load(dly_load), .wake_run(wake_run),
    .cke(sd_cke), .clk_on(sd_clk_on), .gnt(acc_gnt),
    .cmd_valid(lp_cmd_valid), .cmd_code(lp_cmd_code)
  );

  sdlp_ext_hold #(.PASR_W(PASR_W), .DS_W(DS_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .pasr_in(cfg_pasr), .drive_in(cfg_drive),
    .pasr_q(ext_pasr), .drive_q(ext_drive)
  );

  // R10
  gnt_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt |-> sd_cke && sd_clk_on);

endmodule

// File: tb/sdram_lp_ctrl_bench.sv
module sdram_lp_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT = 64;
  localparam int LONG  = 128;
  localparam int WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_lp_mode = 2'd0;
  logic [1:0] cfg_idle_sel = 2'd0;
  logic cfg_lpsdram = 1'b0;
  logic [3:0] cfg_exit_dly = 4'd0;
  logic [2:0] cfg_pasr = 3'd0;
  logic [1:0] cfg_drive = 2'd0;
  logic eng_idle = 1'b1;
  logic acc_req = 1'b0;
  logic ref_req = 1'b0;
  logic acc_gnt, sd_cke, sd_clk_on, lp_cmd_valid;
  logic [2:0] lp_cmd_code;
  logic [2:0] ext_pasr;
  logic [1:0] ext_drive;

  sdram_lp_ctrl #(.SHORT_IDLE(SHORT), .LONG_IDLE(LONG), .DLY_W(4), .PASR_W(3), .DS_W(2))
  u_sdram_lp_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_lp_mode(cfg_lp_mode), .cfg_idle_sel(cfg_idle_sel),
    .cfg_lpsdram(cfg_lpsdram), .cfg_exit_dly(cfg_exit_dly), .cfg_pasr(cfg_pasr),
    .cfg_drive(cfg_drive), .eng_idle(eng_idle), .acc_req(acc_req), .acc_gnt(acc_gnt),
    .ref_req(ref_req), .sd_cke(sd_cke), .sd_clk_on(sd_clk_on),
    .lp_cmd_valid(lp_cmd_valid), .lp_cmd_code(lp_cmd_code),
    .ext_pasr(ext_pasr), .ext_drive(ext_drive)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int cmd_seen = 0;
  bit fin = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference: 0 awake, 1 self-refresh, 2 power-down, 3 deep, 4 recovering
  int m_st = 0, m_run = 0, m_rem = 0, m_cv = 0, m_cc = 0, m_pasr = 0, m_drv = 0;
  always @(posedge clk) begin
    int lim;
    bit q;
    cyc++;
    if (!rst_n) begin
      m_st = 0; m_run = 0; m_rem = 0; m_cv = 0; m_cc = 0; m_pasr = 0; m_drv = 0;
    end else begin
      lim = (cfg_idle_sel == 2'd1) ? SHORT : (cfg_idle_sel == 2'd2) ? LONG : 0;
      q = eng_idle && !acc_req && !ref_req && cfg_lp_mode != 2'd0 &&
          (cfg_lp_mode != 2'd3 || cfg_lpsdram);
      m_cv = 0;
      if (m_st == 0) begin
        if (!q) m_run = 0;
        else if (m_run >= lim) begin
          m_st = int'(cfg_lp_mode); m_cv = 1; m_cc = int'(cfg_lp_mode); m_run = 0;
        end else m_run++;
      end else if (m_st == 4) begin
        m_rem--;
        if (m_rem == 0) m_st = 0;
      end else if (acc_req || (ref_req && m_st != 3)) begin
        m_cv = 1; m_cc = 4;
        if (m_st == 2 || cfg_exit_dly == 4'd0) m_st = 0;
        else begin m_st = 4; m_rem = int'(cfg_exit_dly); end
      end
      m_pasr = int'(cfg_pasr);
      m_drv = int'(cfg_drive);
    end
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      check(sd_cke == (m_st == 0 || m_st == 4), "R6 cke vs model", int'(sd_cke), int'(m_st == 0 || m_st == 4));
      check(sd_clk_on == (m_st != 1 && m_st != 3), "R7 clk_on vs model", int'(sd_clk_on), int'(m_st != 1 && m_st != 3));
      check(acc_gnt == (m_st == 0), "R10 gnt vs model", int'(acc_gnt), int'(m_st == 0));
      check(int'(lp_cmd_valid) == m_cv, "R2 cmd_valid vs model", int'(lp_cmd_valid), m_cv);
      if (m_cv == 1) check(int'(lp_cmd_code) == m_cc, "R2 cmd_code vs model", int'(lp_cmd_code), m_cc);
      check(int'(ext_pasr) == m_pasr && int'(ext_drive) == m_drv, "R11 held fields vs model",
            int'({ext_pasr, ext_drive}), (m_pasr << 2) | m_drv);
      if (lp_cmd_valid) cmd_seen++;
    end
  end

  always @(posedge clk) begin
    if (cyc >= WD_LIMIT && !fin) begin
      fin = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic finish_access(int busy);
    while (!acc_gnt) @(negedge clk);
    @(negedge clk);
    acc_req = 1'b0;
    eng_idle = 1'b0;
    repeat (busy) @(negedge clk);
    eng_idle = 1'b1;
  endtask

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(sd_cke && sd_clk_on && acc_gnt && !lp_cmd_valid, "R1 reset outputs",
          int'({sd_cke, sd_clk_on, acc_gnt, lp_cmd_valid}), 4'b1110);

    // R9 disabled mode never commands
    snap = cmd_seen;
    repeat (150) @(negedge clk);
    check(cmd_seen == snap, "R9 commands while disabled", cmd_seen - snap, 0);
    check(sd_cke == 1'b1, "R9 cke while disabled", int'(sd_cke), 1);

    // R4 alias of immediate entry, power-down
    eng_idle = 1'b0; cfg_lp_mode = 2'd2; cfg_idle_sel = 2'd3;
    @(negedge clk);
    eng_idle = 1'b1;
    @(negedge clk);
    check(sd_cke == 1'b0, "R4 immediate entry", int'(sd_cke), 0);
    check(sd_clk_on == 1'b1, "R6 clock kept in power-down", int'(sd_clk_on), 1);
    check(acc_gnt == 1'b0, "R10 no grant while asleep", int'(acc_gnt), 0);

    // R6 access wakes power-down, re-entry after access
    acc_req = 1'b1;
    @(negedge clk);
    check(sd_cke && acc_gnt, "R6 wake on access", int'({sd_cke, acc_gnt}), 3);
    @(negedge clk);
    acc_req = 1'b0; eng_idle = 1'b0;
    repeat (3) @(negedge clk);
    eng_idle = 1'b1;
    @(negedge clk);
    check(sd_cke == 1'b0, "R6 re-entry after access", int'(sd_cke), 0);

    // R6 refresh wakes power-down
    ref_req = 1'b1;
    @(negedge clk);
    check(sd_cke == 1'b1, "R6 wake on refresh", int'(sd_cke), 1);
    ref_req = 1'b0;
    @(negedge clk);

    // R3 short timeout into self-refresh
    cfg_lp_mode = 2'd1; cfg_idle_sel = 2'd1; cfg_exit_dly = 4'd5;
    acc_req = 1'b1;
    finish_access(2);
    repeat (SHORT) @(negedge clk);
    check(sd_cke == 1'b1, "R3 still awake at limit", int'(sd_cke), 1);
    @(negedge clk);
    check(sd_cke == 1'b0, "R3 entry after short timeout", int'(sd_cke), 0);
    check(sd_clk_on == 1'b0, "R7 clock stopped in self-refresh", int'(sd_clk_on), 0);

    // R7 recovery wait of 5 cycles
    acc_req = 1'b1;
    @(negedge clk);
    check(sd_cke && sd_clk_on && !acc_gnt, "R7 exit raises cke, holds grant",
          int'({sd_cke, sd_clk_on, acc_gnt}), 3'b110);
    repeat (4) @(negedge clk);
    check(acc_gnt == 1'b0, "R7 grant held during recovery", int'(acc_gnt), 0);
    @(negedge clk);
    check(acc_gnt == 1'b1, "R7 grant after recovery", int'(acc_gnt), 1);
    @(negedge clk);
    acc_req = 1'b0; eng_idle = 1'b0;
    repeat (2) @(negedge clk);
    eng_idle = 1'b1;

    // R5 restart of the idle count
    repeat (40) @(negedge clk);
    eng_idle = 1'b0;
    @(negedge clk);
    eng_idle = 1'b1;
    repeat (SHORT) @(negedge clk);
    check(sd_cke == 1'b1, "R5 count restarted", int'(sd_cke), 1);
    @(negedge clk);
    check(sd_cke == 1'b0, "R5 entry after restarted count", int'(sd_cke), 0);

    // R12 zero recovery
    cfg_exit_dly = 4'd0;
    acc_req = 1'b1;
    @(negedge clk);
    check(acc_gnt == 1'b1, "R12 grant with zero recovery", int'(acc_gnt), 1);
    @(negedge clk);
    acc_req = 1'b0; eng_idle = 1'b0;
    @(negedge clk);

    // R8 deep power-down needs low-power memory type
    cfg_lp_mode = 2'd3; cfg_idle_sel = 2'd0; cfg_lpsdram = 1'b0;
    eng_idle = 1'b1;
    repeat (20) @(negedge clk);
    check(sd_cke == 1'b1, "R8 no deep entry on standard type", int'(sd_cke), 1);
    cfg_lpsdram = 1'b1;
    @(negedge clk);
    check(!sd_cke && !sd_clk_on, "R8 deep entry", int'({sd_cke, sd_clk_on}), 0);
    ref_req = 1'b1;
    repeat (5) @(negedge clk);
    check(sd_cke == 1'b0, "R8 refresh ignored in deep", int'(sd_cke), 0);
    ref_req = 1'b0;
    cfg_exit_dly = 4'd3; cfg_lp_mode = 2'd2; cfg_idle_sel = 2'd2;
    acc_req = 1'b1;
    @(negedge clk);
    check(sd_cke && !acc_gnt, "R8 deep exit with recovery", int'({sd_cke, acc_gnt}), 2'b10);
    finish_access(2);

    // R3 long timeout into power-down, R2 entry code
    repeat (LONG) @(negedge clk);
    check(sd_cke == 1'b1, "R3 still awake at long limit", int'(sd_cke), 1);
    @(negedge clk);
    check(sd_cke == 1'b0, "R3 entry after long timeout", int'(sd_cke), 0);
    check(lp_cmd_valid && lp_cmd_code == 3'd2, "R2 power-down entry code",
          int'(lp_cmd_code), 2);

    // R11 held fields do not disturb the sequence
    cfg_pasr = 3'd5; cfg_drive = 2'd2;
    @(negedge clk);
    check(ext_pasr == 3'd5 && ext_drive == 2'd2, "R11 held fields",
          int'({ext_pasr, ext_drive}), 22);
    check(sd_cke == 1'b0, "R11 state untouched", int'(sd_cke), 0);

    // R9 disabling after activity
    cfg_lp_mode = 2'd0;
    acc_req = 1'b1;
    finish_access(1);
    @(negedge clk);
    snap = cmd_seen;
    repeat (150) @(negedge clk);
    check(cmd_seen == snap, "R9 no entry once disabled", cmd_seen - snap, 0);
    check(sd_cke == 1'b1, "R9 cke high once disabled", int'(sd_cke), 1);

    fin = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule